// File: doc/BRIEF.md
# Command-Driven SPI Master

This block is an SPI master that runs one whole message for each command written by software. Software first loads outgoing bytes into a local transmit buffer. It then sets the shift rate, clock polarity and phase in a configuration register, and the byte count and a transfer type in a message register. A command write with the start opcode launches the message. The command also carries a prepend length and the number of the target device.

The block drives the selected chip-select line low for the whole message and shifts every byte MSB first. Received bytes go into a local receive buffer. Chip select is released right after the last byte. A done flag is then set, and that flag reaches the interrupt line when the mask allows it. A non-zero prepend length turns the message into a write-then-read exchange: the leading bytes are only sent, and the rest are only received.

The design assumes a 100 MHz system clock. The seven shift rates are derived from it by dividing the bit period by 5, 8, 16, 32, 64, 128 or 256.

Top module: `spi_cmd_master`

## Requirements
- R1: After reset every chip-select line is high, SCK is low, the interrupt is low, and both the busy flag (register 5, bit 0) and the done flag (register 3, bit 0) read 0.
- R2: With type 0 (full duplex) and no prepend, byte i of the transmit buffer goes out on MOSI MSB first, and byte i received on MISO is stored at receive-buffer index i.
- R3: With type 2 (write only) and no prepend, MOSI carries the transmit bytes and the receive buffer is left unchanged.
- R4: With type 1 (read only) and no prepend, MOSI stays low for all bytes and received byte i is stored at receive index i.
- R5: A prepend length P from 1 to 15 (command bits 7:4) makes bytes 0..P-1 transmit-only from the transmit buffer. The remaining bytes keep MOSI low, and the receive bytes are stored from index 0 upward. A message may then hold up to the buffer depth plus 15 bytes.
- R6: The device number (command bits 8 and up) selects exactly one chip-select line, which is held low for the whole message. All lines are high between messages.
- R7: Configuration bits 2:0 select a bit period of 5 system clocks for code 0, 4<<code for codes 1 to 6, and 256 for code 7.
- R8: Configuration bit 3 sets the SCK idle level. With bit 4 clear, data is valid at the leading SCK edge; with bit 4 set, data is valid at the trailing SCK edge.
- R9: The done flag is set when a message finishes, and writing a 1 to register 3 bit 0 clears it.
- R10: The interrupt output equals the done flag gated by register 4 bit 0; a mask of 0 keeps the interrupt low.
- R11: The busy flag reads 1 while a message runs, and a start command written during that time has no effect.
- R12: A command whose opcode (bits 1:0) is not 01, or a start with a byte count (register 1, low bits) of zero, starts nothing. The message type sits in register 1 bits 15:14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (100 MHz assumed) |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register/buffer write strobe |
| reg_addr | input | $clog2(DEPTH)+2 | Address: top two bits pick registers (00), transmit buffer (01) or receive buffer (10) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| irq | output | 1 | Masked message-done interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The assertions assume that the register port delivers at most one write per cycle. They also assume that the slave changes MISO only on the SCK edge opposite to the sampling edge, so the value seen half a bit period later is settled. The stimulus keeps every byte count within the buffer depth, or within depth plus 15 with a prepend. It uses device numbers below the number of chip selects, and it applies reset for several cycles so that the configuration registers are defined before any check looks back in time. The slave model in the bench changes MISO strictly on the non-sampling edge of the active mode.

// File: rtl/spi_cmd_pkg.sv
// Shared types and constants of the command-driven SPI master.
// Assumes a 100 MHz system clock for the rate table.
package spi_cmd_pkg;

    // Transfer type held in the message register.
    typedef enum logic [1:0] {
        MT_FULL   = 2'd0,
        MT_HREAD  = 2'd1,
        MT_HWRITE = 2'd2,
        MT_RSVD   = 2'd3
    } msg_type_e;

    // Shift engine phases.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_BITS  = 2'd2,
        ST_HOLD  = 2'd3
    } eng_state_e;

    localparam logic [1:0] OP_START = 2'b01;

    // Register indices inside the control region.
    localparam int REG_CFG  = 0;
    localparam int REG_MSG  = 1;
    localparam int REG_CMD  = 2;
    localparam int REG_IST  = 3;
    localparam int REG_IMSK = 4;
    localparam int REG_BUSY = 5;

    // Address regions (top two address bits).
    localparam logic [1:0] RGN_CTRL = 2'b00;
    localparam logic [1:0] RGN_TX   = 2'b01;
    localparam logic [1:0] RGN_RX   = 2'b10;

    // Bit period in system clocks for a rate code.
    function automatic logic [8:0] bit_period(input logic [2:0] sel);
        if (sel == 3'd0) return 9'd5;
        if (sel == 3'd7) return 9'd256;
        return 9'd4 << sel;
    endfunction

endpackage

// File: rtl/spi_cmd_buf.sv
// Byte buffer: one synchronous write port, one combinational read port.
// Assumes the contents need no reset; readers only use written entries.
module spi_cmd_buf #(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [7:0]       rdata
);
    logic [7:0] mem [DEPTH];

    // Store a byte on a write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/spi_cmd_regs.sv
// Register file: configuration, message and command decode, done status,
// interrupt mask and the read mux over registers and the receive buffer.
// Assumes one access per cycle; start is only issued while the engine idles.
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int CNT_W = 7,
    parameter int ID_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [IDX_W+1:0] reg_addr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    output logic             irq_o,
    input  logic             busy_i,
    input  logic             done_i,
    input  logic [7:0]       rx_rdata_i,
    output logic [IDX_W-1:0] rx_raddr_o,
    output logic             tx_we_o,
    output logic [IDX_W-1:0] tx_waddr_o,
    output logic [7:0]       tx_wdata_o,
    output logic             start_o,
    output logic [2:0]       rate_o,
    output logic             cpol_o,
    output logic             cpha_o,
    output logic [CNT_W-1:0] count_o,
    output msg_type_e        type_o,
    output logic [3:0]       prep_o,
    output logic [ID_W-1:0]  id_o
);
    logic [1:0]       region;
    logic [IDX_W-1:0] idx;
    logic             wr_ctrl;
    logic [2:0]       rate_q;
    logic             cpol_q, cpha_q;
    logic [CNT_W-1:0] count_q;
    msg_type_e        type_q;
    logic             done_q, mask_q;

    assign region  = reg_addr[IDX_W+1:IDX_W];
    assign idx     = reg_addr[IDX_W-1:0];
    assign wr_ctrl = reg_we && (region == RGN_CTRL);

    // Buffer access paths.
    assign tx_we_o    = reg_we && (region == RGN_TX);
    assign tx_waddr_o = idx;
    assign tx_wdata_o = reg_wdata[7:0];
    assign rx_raddr_o = idx;

    // Start only on a valid opcode, a non-zero count and an idle engine.
    assign start_o = wr_ctrl && (idx == IDX_W'(REG_CMD)) &&
                     (reg_wdata[1:0] == OP_START) && !busy_i && (count_q != '0);
    assign prep_o  = reg_wdata[7:4];
    assign id_o    = reg_wdata[8 +: ID_W];

    assign rate_o  = rate_q;
    assign cpol_o  = cpol_q;
    assign cpha_o  = cpha_q;
    assign count_o = count_q;
    assign type_o  = type_q;
    assign irq_o   = done_q & mask_q;

    // Configuration, message and mask register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q  <= '0;
            cpol_q  <= 1'b0;
            cpha_q  <= 1'b0;
            count_q <= '0;
            type_q  <= MT_FULL;
            mask_q  <= 1'b0;
        end else if (wr_ctrl) begin
            if (idx == IDX_W'(REG_CFG)) begin
                rate_q <= reg_wdata[2:0];
                cpol_q <= reg_wdata[3];
                cpha_q <= reg_wdata[4];
            end
            if (idx == IDX_W'(REG_MSG)) begin
                count_q <= reg_wdata[CNT_W-1:0];
                type_q  <= msg_type_e'(reg_wdata[15:14]);
            end
            if (idx == IDX_W'(REG_IMSK)) mask_q <= reg_wdata[0];
        end
    end

    // Done flag: set by the engine, cleared by writing a one; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else if (done_i)
            done_q <= 1'b1;
        else if (wr_ctrl && (idx == IDX_W'(REG_IST)) && reg_wdata[0])
            done_q <= 1'b0;
    end

    // Read mux over the register region and the receive buffer.
    always_comb begin
        reg_rdata = '0;
        if (region == RGN_RX) begin
            reg_rdata[7:0] = rx_rdata_i;
        end else if (region == RGN_CTRL) begin
            case (idx)
                IDX_W'(REG_CFG):  reg_rdata[4:0] = {cpha_q, cpol_q, rate_q};
                IDX_W'(REG_MSG):  begin
                    reg_rdata[CNT_W-1:0] = count_q;
                    reg_rdata[15:14]     = type_q;
                end
                IDX_W'(REG_IST):  reg_rdata[0] = done_q;
                IDX_W'(REG_IMSK): reg_rdata[0] = mask_q;
                IDX_W'(REG_BUSY): reg_rdata[0] = busy_i;
                default:          reg_rdata = '0;
            endcase
        end
    end

    // R9
    done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> done_q);
endmodule

// File: rtl/spi_cmd_engine.sv
// Shift engine: frames one message with chip select, shifts bytes MSB first,
// handles the prepend split and pulses done after chip select is released.
// Assumes start only arrives while idle and count is at least one.
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int CNT_W  = 7,
    parameter int ID_W   = 3,
    parameter int NUM_CS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        rate_i,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic [CNT_W-1:0]  count_i,
    input  msg_type_e         type_i,
    input  logic [3:0]        prep_i,
    input  logic [ID_W-1:0]   id_i,
    output logic [IDX_W-1:0]  tx_idx_o,
    input  logic [7:0]        tx_byte_i,
    output logic              rx_we_o,
    output logic [IDX_W-1:0]  rx_idx_o,
    output logic [7:0]        rx_byte_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic [NUM_CS-1:0] cs_n_o
);
    eng_state_e       state;
    logic [8:0]       per_q, half;
    logic [8:0]       cnt;
    logic [2:0]       bitn;
    logic [CNT_W-1:0] byte_idx, next_idx, rx_pos;
    logic [CNT_W-1:0] count_q;
    logic [3:0]       prep_q;
    msg_type_e        type_q;
    logic             cpol_q, cpha_q;
    logic [7:0]       shreg, rxsh;
    logic [NUM_CS-1:0] sel_dec;
    logic             bit_end, last_bit;

    // Byte carries transmit data in this message.
    function automatic logic is_tx(input logic [CNT_W-1:0] i, input logic [3:0] p,
                                   input msg_type_e t);
        if (p != 4'd0) return i < CNT_W'(p);
        return t != MT_HREAD;
    endfunction

    // Byte is stored in the receive buffer in this message.
    function automatic logic is_rx(input logic [CNT_W-1:0] i, input logic [3:0] p,
                                   input msg_type_e t);
        if (p != 4'd0) return i >= CNT_W'(p);
        return t != MT_HWRITE;
    endfunction

    // One-hot decode of the device number onto the select lines.
    for (genvar k = 0; k < NUM_CS; k++) begin : g_dec
        assign sel_dec[k] = (id_i == ID_W'(k));
    end

    assign half     = per_q >> 1;
    assign bit_end  = (state == ST_BITS) && (cnt == per_q - 9'd1);
    assign last_bit = bit_end && (bitn == 3'd7);
    assign next_idx = byte_idx + 1'b1;
    assign rx_pos   = byte_idx - CNT_W'(prep_q);

    assign tx_idx_o  = (state == ST_BITS) ? next_idx[IDX_W-1:0] : '0;
    assign rx_we_o   = last_bit && is_rx(byte_idx, prep_q, type_q);
    assign rx_idx_o  = rx_pos[IDX_W-1:0];
    assign rx_byte_o = rxsh;
    assign busy_o    = (state != ST_IDLE);
    assign mosi_o    = shreg[7];

    // Message sequencing: setup, eight bits per byte, hold, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bitn     <= '0;
            byte_idx <= '0;
            per_q    <= 9'd5;
            count_q  <= '0;
            prep_q   <= '0;
            type_q   <= MT_FULL;
            cpol_q   <= 1'b0;
            cpha_q   <= 1'b0;
            shreg    <= '0;
            rxsh     <= '0;
            cs_n_o   <= '1;
            done_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: if (start_i) begin
                    state   <= ST_SETUP;
                    cnt     <= '0;
                    per_q   <= bit_period(rate_i);
                    count_q <= count_i;
                    prep_q  <= prep_i;
                    type_q  <= type_i;
                    cpol_q  <= cpol_i;
                    cpha_q  <= cpha_i;
                    cs_n_o  <= ~sel_dec;
                end
                ST_SETUP: if (cnt == half - 9'd1) begin
                    state    <= ST_BITS;
                    cnt      <= '0;
                    bitn     <= '0;
                    byte_idx <= '0;
                    shreg    <= is_tx('0, prep_q, type_q) ? tx_byte_i : 8'h00;
                end else begin
                    cnt <= cnt + 9'd1;
                end
                ST_BITS: begin
                    if (cnt == half) rxsh <= {rxsh[6:0], miso_i};
                    if (bit_end) begin
                        cnt <= '0;
                        if (bitn == 3'd7) begin
                            bitn <= '0;
                            if (byte_idx == count_q - 1'b1) begin
                                state <= ST_HOLD;
                                shreg <= 8'h00;
                            end else begin
                                byte_idx <= next_idx;
                                shreg    <= is_tx(next_idx, prep_q, type_q) ? tx_byte_i : 8'h00;
                            end
                        end else begin
                            bitn  <= bitn + 3'd1;
                            shreg <= {shreg[6:0], 1'b0};
                        end
                    end else begin
                        cnt <= cnt + 9'd1;
                    end
                end
                ST_HOLD: if (cnt == half - 9'd1) begin
                    state  <= ST_IDLE;
                    cnt    <= '0;
                    cs_n_o <= '1;
                    done_o <= 1'b1;
                end else begin
                    cnt <= cnt + 9'd1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Serial clock: idle level outside bits, active half chosen by phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sclk_o <= 1'b0;
        else if (state == ST_BITS)
            sclk_o <= cpol_q ^ (cpha_q ? (cnt < half) : (cnt >= half));
        else
            sclk_o <= cpol_i;
    end

    // R6
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));
    // R6
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (&cs_n_o));
    // R11
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (state == ST_IDLE));
    // R2
    rx_in_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we_o |-> !(&cs_n_o));
    // R8
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && $past(state == ST_IDLE)) |-> (sclk_o == $past(cpol_i)));
endmodule

// File: rtl/spi_cmd_master.sv
// Top of the command-driven SPI master: register file, transmit and
// receive byte buffers and the shift engine.
// Assumes a 100 MHz clock and byte counts within the documented limits.
module spi_cmd_master
    import spi_cmd_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int NUM_CS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_we,
    input  logic [$clog2(DEPTH)+1:0]   reg_addr,
    input  logic [15:0]                reg_wdata,
    output logic [15:0]                reg_rdata,
    output logic                       irq,
    output logic                       sclk,
    output logic                       mosi,
    input  logic                       miso,
    output logic [NUM_CS-1:0]          cs_n
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 16);
    localparam int ID_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

    logic             busy, done, start;
    logic [2:0]       rate;
    logic             cpol, cpha;
    logic [CNT_W-1:0] count;
    msg_type_e        mtype;
    logic [3:0]       prep;
    logic [ID_W-1:0]  dev_id;
    logic             tx_we, rx_we;
    logic [IDX_W-1:0] tx_waddr, tx_raddr, rx_waddr, rx_raddr;
    logic [7:0]       tx_wdata, tx_rdata, rx_wdata, rx_rdata;

    spi_cmd_regs #(.IDX_W(IDX_W), .CNT_W(CNT_W), .ID_W(ID_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq),
        .busy_i(busy), .done_i(done), .rx_rdata_i(rx_rdata), .rx_raddr_o(rx_raddr),
        .tx_we_o(tx_we), .tx_waddr_o(tx_waddr), .tx_wdata_o(tx_wdata),
        .start_o(start), .rate_o(rate), .cpol_o(cpol), .cpha_o(cpha),
        .count_o(count), .type_o(mtype), .prep_o(prep), .id_o(dev_id)
    );

    spi_cmd_buf #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_txbuf (
        .clk(clk), .we(tx_we), .waddr(tx_waddr), .wdata(tx_wdata),
        .raddr(tx_raddr), .rdata(tx_rdata)
    );

    spi_cmd_buf #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_rxbuf (
        .clk(clk), .we(rx_we), .waddr(rx_waddr), .wdata(rx_wdata),
        .raddr(rx_raddr), .rdata(rx_rdata)
    );

    spi_cmd_engine #(.IDX_W(IDX_W), .CNT_W(CNT_W), .ID_W(ID_W), .NUM_CS(NUM_CS)) u_eng (
        .clk(clk), .rst_n(rst_n), .start_i(start), .rate_i(rate), .cpol_i(cpol),
        .cpha_i(cpha), .count_i(count), .type_i(mtype), .prep_i(prep), .id_i(dev_id),
        .tx_idx_o(tx_raddr), .tx_byte_i(tx_rdata), .rx_we_o(rx_we), .rx_idx_o(rx_waddr),
        .rx_byte_o(rx_wdata), .busy_o(busy), .done_o(done), .sclk_o(sclk),
        .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n)
    );
endmodule

// File: tb/spi_cmd_master_test.sv
module spi_cmd_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 64;
    localparam int NUM_CS = 8;
    localparam int IW     = $clog2(DEPTH);
    localparam int AW     = IW + 2;

    logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, miso = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    wire  [15:0] reg_rdata;
    wire  irq, sclk, mosi;
    wire  [NUM_CS-1:0] cs_n;

    int checks = 0, errors = 0;

    spi_cmd_master #(.DEPTH(DEPTH), .NUM_CS(NUM_CS)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- slave model ----------------
    logic s_cpol = 1'b0, s_cpha = 1'b0;
    logic [7:0] slv_tx [0:127];
    logic [7:0] slv_rx [0:127];
    logic [7:0] tx_ref [0:127];
    logic [7:0] rx_before [0:127];
    int in_bits = 0, out_bits = 0, cs_starts = 0;
    time t0 = 0, t1 = 0;
    logic [NUM_CS-1:0] cs_seen = '0;
    wire cs_act = ~&cs_n;

    always @(posedge cs_act) begin
        cs_starts++;
        in_bits  = 0;
        out_bits = 0;
        cs_seen  = ~cs_n;
        if (!s_cpha) begin
            miso = slv_tx[0][7];
            out_bits = 1;
        end
    end

    always @(sclk) begin
        if (cs_act === 1'b1) begin
            if ((sclk != s_cpol) ^ s_cpha) begin
                slv_rx[in_bits/8][7-(in_bits%8)] = mosi;
                if (in_bits == 0) t0 = $time;
                if (in_bits == 1) t1 = $time;
                in_bits++;
            end else begin
                miso = slv_tx[out_bits/8][7-(out_bits%8)];
                out_bits++;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [AW-1:0] ra(input int i);
        return {2'b00, IW'(i)};
    endfunction
    function automatic logic [AW-1:0] ta(input int i);
        return {2'b01, IW'(i)};
    endfunction
    function automatic logic [AW-1:0] xa(input int i);
        return {2'b10, IW'(i)};
    endfunction
    function automatic int exp_period(input int sel);
        if (sel == 0) return 5;
        if (sel == 7) return 256;
        return 4 << sel;
    endfunction

    task automatic wait_idle();
        logic [15:0] d;
        for (int n = 0; n < 50000; n++) begin
            rd(ra(5), d);
            if (d[0] == 1'b0) break;
        end
    endtask

    // Run one message and check every observable outcome.
    task automatic run_msg(input int count, input int mtype, input int prep, input int id,
                           input int sel, input bit cpol, input bit cpha, input bit mask);
        logic [15:0] d;
        int starts0, nrx;
        string tag;
        tag = (prep > 0) ? "R5" : (mtype == 0) ? "R2" : (mtype == 1) ? "R4" : "R3";
        s_cpol = cpol; s_cpha = cpha;
        wr(ra(0), 16'({cpha, cpol, 3'(sel)}));
        for (int i = 0; i < 128; i++) slv_tx[i] = 8'($urandom);
        for (int i = 0; i < count && i < DEPTH; i++) begin
            tx_ref[i] = 8'($urandom);
            wr(ta(i), {8'h00, tx_ref[i]});
        end
        if (mtype == 2 && prep == 0)
            for (int i = 0; i < count; i++) begin rd(xa(i), d); rx_before[i] = d[7:0]; end
        wr(ra(4), {15'd0, mask});
        wr(ra(3), 16'h0001);
        wr(ra(1), 16'(mtype << 14) | 16'(count));
        starts0 = cs_starts;
        wr(ra(2), 16'(id << 8) | 16'(prep << 4) | 16'h0001);
        wait_idle();
        chk(cs_starts - starts0 == 1, "R6 one frame", cs_starts - starts0, 1);
        chk(cs_seen == NUM_CS'(1 << id), "R6 select", int'(cs_seen), 1 << id);
        chk(&cs_n, "R6 release", int'(cs_n), 255);
        chk(sclk == cpol, "R8 idle level", int'(sclk), int'(cpol));
        chk(in_bits == count * 8, {tag, " bit count"}, in_bits, count * 8);
        chk((t1 - t0) == time'(exp_period(sel) * CLK_PERIOD), "R7 period",
            int'((t1 - t0) / CLK_PERIOD), exp_period(sel));
        nrx = 0;
        for (int i = 0; i < count; i++) begin
            logic [7:0] e;
            bit txb, rxb;
            txb = (prep > 0) ? (i < prep) : (mtype != 1);
            rxb = (prep > 0) ? (i >= prep) : (mtype != 2);
            e = txb ? tx_ref[i] : 8'h00;
            chk(slv_rx[i] == e, {tag, " mosi byte"}, int'(slv_rx[i]), int'(e));
            if (rxb) begin
                rd(xa(i - prep), d);
                chk(d[7:0] == slv_tx[i], {tag, " rx byte"}, int'(d[7:0]), int'(slv_tx[i]));
                nrx++;
            end
        end
        if (mtype == 2 && prep == 0)
            for (int i = 0; i < count; i++) begin
                rd(xa(i), d);
                chk(d[7:0] === rx_before[i], "R3 rx untouched", int'(d[7:0]), int'(rx_before[i]));
            end
        rd(ra(3), d);
        chk(d[0] == 1'b1, "R9 done set", int'(d[0]), 1);
        chk(irq == mask, "R10 irq gating", int'(irq), int'(mask));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 190000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [15:0] d;
        int starts0;
        process::self().srandom(32'd7);
        void'($urandom(32'd7));
        for (int i = 0; i < 128; i++) begin slv_tx[i] = '0; slv_rx[i] = '0; tx_ref[i] = '0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(&cs_n, "R1 cs", int'(cs_n), 255);
        chk(sclk == 1'b0, "R1 sclk", int'(sclk), 0);
        chk(irq == 1'b0, "R1 irq", int'(irq), 0);
        rd(ra(5), d); chk(d[0] == 1'b0, "R1 busy", int'(d[0]), 0);
        rd(ra(3), d); chk(d[0] == 1'b0, "R1 done", int'(d[0]), 0);

        // Directed corners
        run_msg(4, 0, 0, 0, 0, 0, 0, 1);            // R2 basic
        run_msg(3, 2, 0, 3, 1, 1, 1, 1);            // R3
        run_msg(5, 1, 0, 7, 2, 0, 1, 0);            // R4, R10 mask off
        run_msg(DEPTH, 0, 0, 2, 0, 1, 0, 1);        // R2 full depth
        run_msg(DEPTH + 15, 1, 15, 4, 0, 0, 1, 1);  // R5 maximum length
        run_msg(3, 0, 1, 5, 1, 1, 0, 1);            // R5 single prepend byte
        run_msg(1, 0, 0, 1, 6, 0, 0, 1);            // R7 code 6
        run_msg(1, 2, 0, 6, 7, 1, 1, 1);            // R7 code 7

        // R10: enable mask after done with mask off
        run_msg(2, 0, 0, 0, 0, 0, 0, 0);
        wr(ra(4), 16'h0001);
        chk(irq == 1'b1, "R10 mask enable", int'(irq), 1);
        // R9 clear
        wr(ra(3), 16'hFFFF);
        rd(ra(3), d);
        chk(d[0] == 1'b0, "R9 clear", int'(d[0]), 0);
        chk(irq == 1'b0, "R10 irq follows clear", int'(irq), 0);

        // R11: second start during a message is ignored
        s_cpol = 0; s_cpha = 0;
        wr(ra(0), 16'h0002);
        wr(ra(1), 16'd4);
        starts0 = cs_starts;
        wr(ra(2), 16'h0101);
        rd(ra(5), d);
        chk(d[0] == 1'b1, "R11 busy", int'(d[0]), 1);
        wr(ra(2), 16'h0501);
        wait_idle();
        chk(cs_starts - starts0 == 1, "R11 ignored start", cs_starts - starts0, 1);
        chk(cs_seen == NUM_CS'(1 << 1), "R11 first device kept", int'(cs_seen), 2);

        // R12: bad opcode and zero count
        starts0 = cs_starts;
        wr(ra(2), 16'h0002);
        repeat (20) @(negedge clk);
        rd(ra(5), d);
        chk(d[0] == 1'b0 && cs_starts == starts0, "R12 bad opcode", cs_starts - starts0, 0);
        wr(ra(1), 16'd0);
        wr(ra(2), 16'h0001);
        repeat (20) @(negedge clk);
        rd(ra(5), d);
        chk(d[0] == 1'b0 && cs_starts == starts0, "R12 zero count", cs_starts - starts0, 0);

        // Random messages
        for (int k = 0; k < 24; k++) begin
            int ty, pr, cnt;
            ty  = $urandom % 3;
            pr  = ($urandom % 3 == 0) ? 1 + $urandom % 15 : 0;
            cnt = pr + 1 + $urandom % 16;
            run_msg(cnt, ty, pr, $urandom % NUM_CS, $urandom % 3,
                    1'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule